// File: doc/BRIEF.md
# Unsigned Divider with Power-of-Two Bypass and Early Stop

This block divides one unsigned W-bit operand by another. A single-cycle `start` pulse, given while the unit is idle, captures both operands. The controller then makes one classification cycle. A zero divisor ends the job at once with a divide-by-zero flag. A divisor with exactly one bit set is handled by a right shift of the dividend and a low-bit mask. Every other divisor runs an iterative non-restoring loop that retires one quotient bit per clock.

During the loop, the controller checks each cycle whether the partial remainder is exactly zero and whether every dividend bit not yet brought down is zero. If both hold, the remaining quotient bits must all be zero. The loop then stops, and the quotient built so far is shifted left into place. The result, the flag and a count of the cycles the job used are registered and stay valid until the next job completes.

The controller has four states. `ST_IDLE` waits for `start` (idle to classify). `ST_CLASSIFY` goes to `ST_DONE` for a zero or power-of-two divisor (bypass) and to `ST_ITER` otherwise (enter loop). `ST_ITER` stays put while bits remain (step). It goes to `ST_DONE` when no iterations are left, applying the final remainder correction (finish), or when the stop test holds (early exit). `ST_DONE` always returns to `ST_IDLE` (retire).

Top module: `fastdiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `div_by_zero`, `quotient`, `remainder` and `cycles` are all zero.
- R2: `start` is taken only in the idle state. A `start` seen while a job is running or finishing has no effect on that job's results.
- R3: For a nonzero divisor, the completed job gives `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor, so `remainder` < divisor.
- R4: A divisor with exactly one bit set completes with `cycles` = 2. The cycle count runs from the `start` edge up to and including the edge that raises `done`.
- R5: A zero divisor completes with `cycles` = 2, `div_by_zero` = 1, `quotient` all ones and `remainder` equal to the dividend.
- R6: Any other divisor with no early stop completes with `cycles` = W + 3.
- R7: Let s be the smallest value in 0..W-1 for which the top s bits of the dividend, taken as a number, are a multiple of the divisor and the low W - s bits of the dividend are all zero. If such an s exists, a non-power-of-two divisor completes with `cycles` = s + 3.
- R8: `busy` is high from the cycle after `start` is taken until `done` rises. `done` is high for exactly one cycle. `quotient`, `remainder`, `div_by_zero` and `cycles` hold their values after `done` falls.
- R9: `div_by_zero` is low for any job with a nonzero divisor, including a job that follows one with a zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present operands |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient of the last completed job |
| remainder | output | W | Remainder of the last completed job |
| div_by_zero | output | 1 | Last completed job had a zero divisor |
| cycles | output | $clog2(W+4)+1 | Clock cycles used by the last completed job |

## Verification
Uniform random operands almost never cause an early stop after a nonzero number of steps. That needs a dividend whose high part is an exact multiple of the divisor and whose low part is all zeros. The stimulus therefore builds such dividends on purpose: it picks a prefix length s and a multiple of a non-power-of-two divisor that fits in s bits, then shifts it to the top of the word. Every run checks the exact cycle count against the smallest-stopping-point rule.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_ITER,
        ST_DONE
    } fdiv_state_e;
endpackage

// File: rtl/fdiv_pow2.sv
`timescale 1ns/1ps
module fdiv_pow2 #(
    parameter int W = 16,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  m,
    output logic          is_pow2,
    output logic [SW-1:0] shamt,
    output logic [W-1:0]  low_mask
);
    assign low_mask = m - W'(1);
    assign is_pow2  = (m != '0) && ((m & low_mask) == '0);

    always_comb begin
        shamt = '0;
        for (int i = 0; i < W; i++) begin
            if (m[i]) shamt = SW'(i);
        end
    end
endmodule

// File: rtl/fdiv_nr_step.sv
`timescale 1ns/1ps
module fdiv_nr_step #(
    parameter int W = 16
) (
    input  logic [W:0]   a,
    input  logic [W-1:0] q,
    input  logic [W-1:0] m,
    output logic [W:0]   a_nxt,
    output logic [W-1:0] q_nxt
);
    logic [W:0] shifted;
    logic [W:0] mx;

    assign mx      = {1'b0, m};
    assign shifted = {a[W-1:0], q[W-1]};
    assign a_nxt   = a[W] ? (shifted + mx) : (shifted - mx);
    assign q_nxt   = {q[W-2:0], ~a_nxt[W]};
endmodule

// File: rtl/fastdiv_unit.sv
`timescale 1ns/1ps
module fastdiv_unit
    import fdiv_pkg::*;
#(
    parameter int W = 16,
    localparam int CW = $clog2(W + 4) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  dividend,
    input  logic [W-1:0]  divisor,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  quotient,
    output logic [W-1:0]  remainder,
    output logic          div_by_zero,
    output logic [CW-1:0] cycles
);
    localparam int SW = $clog2(W);
    localparam int NW = $clog2(W + 1);

    fdiv_state_e state, nstate;

    logic [W-1:0]  d_r, m_r;
    logic [W:0]    a_r;
    logic [W-1:0]  q_r;
    logic [NW-1:0] n_r;
    logic [CW-1:0] cnt_r;
    logic [W-1:0]  q_out, r_out;
    logic          dbz_r;
    logic [CW-1:0] cyc_r;

    logic          is_pow2;
    logic [SW-1:0] shamt;
    logic [W-1:0]  low_mask;
    logic [W:0]    a_nxt;
    logic [W-1:0]  q_nxt;
    logic [W:0]    a_fix;
    logic [W-1:0]  pend_mask;
    logic          early;

    fdiv_pow2 #(.W(W)) u_pow2 (
        .m(m_r), .is_pow2(is_pow2), .shamt(shamt), .low_mask(low_mask)
    );

    fdiv_nr_step #(.W(W)) u_step (
        .a(a_r), .q(q_r), .m(m_r), .a_nxt(a_nxt), .q_nxt(q_nxt)
    );

    assign a_fix     = a_r + {1'b0, m_r};
    assign pend_mask = ~({W{1'b1}} >> n_r);
    assign early     = (a_r == '0) && ((q_r & pend_mask) == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:     if (start) nstate = ST_CLASSIFY;
            ST_CLASSIFY: nstate = ((m_r == '0) || is_pow2) ? ST_DONE : ST_ITER;
            ST_ITER:     if ((n_r == '0) || early) nstate = ST_DONE;
            ST_DONE:     nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_r   <= '0;
            m_r   <= '0;
            a_r   <= '0;
            q_r   <= '0;
            n_r   <= '0;
            cnt_r <= '0;
            q_out <= '0;
            r_out <= '0;
            dbz_r <= 1'b0;
            cyc_r <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        d_r   <= dividend;
                        m_r   <= divisor;
                        cnt_r <= CW'(1);
                        dbz_r <= 1'b0;
                    end
                end
                ST_CLASSIFY: begin
                    cnt_r <= cnt_r + CW'(1);
                    if (m_r == '0) begin
                        q_out <= '1;
                        r_out <= d_r;
                        dbz_r <= 1'b1;
                        cyc_r <= cnt_r + CW'(1);
                    end else if (is_pow2) begin
                        q_out <= d_r >> shamt;
                        r_out <= d_r & low_mask;
                        cyc_r <= cnt_r + CW'(1);
                    end else begin
                        a_r <= '0;
                        q_r <= d_r;
                        n_r <= NW'(W);
                    end
                end
                ST_ITER: begin
                    cnt_r <= cnt_r + CW'(1);
                    if (n_r == '0) begin
                        q_out <= q_r;
                        r_out <= a_r[W] ? a_fix[W-1:0] : a_r[W-1:0];
                        cyc_r <= cnt_r + CW'(1);
                    end else if (early) begin
                        q_out <= q_r << n_r;
                        r_out <= '0;
                        cyc_r <= cnt_r + CW'(1);
                    end else begin
                        a_r <= a_nxt;
                        q_r <= q_nxt;
                        n_r <= n_r - NW'(1);
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state == ST_CLASSIFY) || (state == ST_ITER);
        done        = (state == ST_DONE);
        quotient    = q_out;
        remainder   = r_out;
        div_by_zero = dbz_r;
        cycles      = cyc_r;
    end

    // R3
    result_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |->
            (({{W{1'b0}}, quotient} * {{W{1'b0}}, m_r}) + {{W{1'b0}}, remainder}
             == {{W{1'b0}}, d_r}));

    // R3
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (remainder < m_r));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(quotient) && $stable(cycles)));

    // R6
    cycle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((cycles >= CW'(2)) && (cycles <= CW'(W + 3))));

    // R5
    dbz_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (m_r == '0 && cycles == CW'(2)));
endmodule

// File: tb/test_fastdiv_unit.sv
`timescale 1ns/1ps
module test_fastdiv_unit;
    localparam int W  = 16;
    localparam int CW = $clog2(W + 4) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  dividend = '0;
    logic [W-1:0]  divisor = '0;
    logic          busy, done, div_by_zero;
    logic [W-1:0]  quotient, remainder;
    logic [CW-1:0] cycles;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fastdiv_unit #(.W(W)) i_fastdiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .div_by_zero(div_by_zero), .cycles(cycles)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_cycles(logic [W-1:0] d, logic [W-1:0] m);
        if (m == '0) return 2;
        if ((m & (m - W'(1))) == '0) return 2;
        for (int s = 0; s < W; s++) begin
            logic [31:0] pre;
            logic [31:0] low;
            pre = 32'(d) >> (W - s);
            low = 32'(d) & ((32'd1 << (W - s)) - 32'd1);
            if (low == 0 && (pre % 32'(m)) == 0) return s + 3;
        end
        return W + 3;
    endfunction

    task automatic run_div(input logic [W-1:0] d, input logic [W-1:0] m, input bit inject);
        int wd;
        logic [W-1:0] eq, er;
        logic [W-1:0] hq;
        logic [CW-1:0] hc;
        int ec;
        string rc;
        @(negedge clk);
        dividend = d;
        divisor  = m;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
        if (inject) begin
            dividend = ~d;
            divisor  = m ^ 16'h0005;
            start    = 1'b1;
        end
        wd = 0;
        while (!done && wd < 100) begin
            @(negedge clk);
            start = 1'b0;
            wd++;
        end
        check(wd < 100, "R8 done reached", 64'(wd), 64'd0);
        ec = exp_cycles(d, m);
        if (m == '0) begin
            eq = '1;
            er = d;
            check(div_by_zero == 1'b1, "R5 flag", 64'(div_by_zero), 64'd1);
        end else begin
            eq = d / m;
            er = d % m;
            check(div_by_zero == 1'b0, "R9 flag clear", 64'(div_by_zero), 64'd0);
        end
        rc = inject ? "R2 quotient" : "R3 quotient";
        check(quotient == eq, rc, 64'(quotient), 64'(eq));
        check(remainder == er, "R3 remainder", 64'(remainder), 64'(er));
        if (m == '0)                       rc = "R5 cycles";
        else if ((m & (m - W'(1))) == '0) rc = "R4 cycles";
        else if (ec == W + 3)              rc = "R6 cycles";
        else                               rc = "R7 cycles";
        check(int'(cycles) == ec, rc, 64'(cycles), 64'(ec));
        hq = quotient;
        hc = cycles;
        @(negedge clk);
        check(done == 1'b0, "R8 done pulse", 64'(done), 64'd0);
        check(quotient == hq && cycles == hc, "R8 hold", 64'(quotient), 64'(hq));
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        #1;
        check(busy == 0 && done == 0 && div_by_zero == 0, "R1 flags", 64'({busy, done, div_by_zero}), 64'd0);
        check(quotient == 0 && remainder == 0 && cycles == 0, "R1 results", 64'(quotient), 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        run_div(16'd0, 16'd3, 1'b0);        // R7 s = 0
        run_div(16'hC000, 16'd3, 1'b0);     // R7 s = 2
        run_div(16'hFFFF, 16'd1, 1'b0);     // R4
        run_div(16'h1234, 16'h8000, 1'b0);  // R4
        run_div(16'd100, 16'd7, 1'b0);      // R6
        run_div(16'hFFFF, 16'hFFFF, 1'b0);  // R6
        run_div(16'd55, 16'd0, 1'b0);       // R5
        run_div(16'd55, 16'd5, 1'b0);       // R9
        run_div(16'hBEEF, 16'd13, 1'b1);    // R2
        run_div(16'h0007, 16'd4, 1'b1);     // R2 on bypass path

        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] d, m;
            int sel;
            sel = int'($urandom % 6);
            d = W'($urandom);
            case (sel)
                0: m = W'($urandom);
                1: m = W'(1) << ($urandom % W);
                2: m = '0;
                3: begin
                    int s;
                    int lim;
                    s = 1 + int'($urandom % (W - 1));
                    m = W'(3 + 2 * ($urandom % 20));
                    lim = ((1 << s) - 1) / int'(m);
                    d = W'((int'($urandom % (lim + 1)) * int'(m)) << (W - s));
                end
                4: m = W'(1 + $urandom % 7);
                default: m = d + W'(1 + $urandom % 100);
            endcase
            run_div(d, m, (i % 37) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule